// File: doc/BRIEF.md
# Atomic-Alias Control Register Bank for a Serial Port

This block is the register file of a serial peripheral. A simple word-addressed bus reaches it through a byte address, a write enable, a read enable, write data and read data. It holds a main control word, a second control word for error-interrupt enables, a 9-bit clock divisor and a status word. The shifter and the FIFOs are not part of it. The block only drives their configuration fields out as named pins, and it reports their levels and flags in the status word.

Each control word takes a group of four word slots. One slot is a plain write. The other three are write-only aliases, and software uses them to clear, set or toggle chosen bits without a read-modify-write sequence. The status word is decoded the same way. Its only writable bit is the sticky receive-overflow flag, and software drops that flag through the status clear alias. The data-buffer address is a window: a write to it becomes a transmit push, and a read from it pops the receive side.

Top module: `spi_csr_bank`

## Requirements
- R1: After reset, the two control words, the divisor and the overflow flag are zero. Read data is zero until the first read.
- R2: A write to the plain slot of a control word stores all 32 bits, and a later read of the same slot returns them. The main control word is at byte offset 0x00 and the second control word at 0x40.
- R3: A write to a clear alias zeroes every stored bit whose write-data bit is 1 and leaves the others unchanged. The clear aliases are at 0x04 (main control) and 0x44 (second control).
- R4: A write to a set alias ORs the write data into the stored word. The set aliases are at 0x08 and 0x48.
- R5: A write to an invert alias XORs the write data into the stored word. The invert aliases are at 0x0C and 0x4C.
- R6: The divisor is at 0x30. It keeps write-data bits 8:0 and drops the higher bits, and a read of it returns those bits zero-extended.
- R7: Main control bit 15 drives module_en, bit 13 idle_stop, bit 5 master_en, bit 16 enh_buf_en, bit 28 hw_ss_en and bit 31 framed_en. Second control bit 10 drives irq_txur_en, bit 11 irq_rxov_en and bit 12 irq_frm_en.
- R8: A read of the status word at 0x10 returns the transmit level in bits 20:16, the receive level in bits 28:24, the receive-empty input in bit 5 and the overflow flag in bit 6. All other bits read as zero.
- R9: A pulse on rx_ovf_evt sets the overflow flag, and the flag stays set until a write to the status clear alias 0x14 with data bit 6 set. An event in the same cycle as that write wins. Plain, set and invert writes to status do not change the flag.
- R10: A write to 0x20 raises tx_push for that cycle, with tx_push_data equal to the write data. A read of 0x20 raises rx_pop for that cycle and returns rx_pop_data.
- R11: Reads of alias slots, unused slots, offsets above 0x4C and addresses whose two low bits are not zero return zero. Writes to those unused addresses change nothing.
- R12: Read data is registered. It takes its new value on the clock edge at which the read enable is sampled and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tx_push | output | 1 | Transmit push strobe |
| tx_push_data | output | 32 | Word pushed to transmit side |
| rx_pop | output | 1 | Receive pop strobe |
| rx_pop_data | input | 32 | Head word of receive side |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_empty | input | 1 | Receive FIFO is empty |
| rx_ovf_evt | input | 1 | Receive overflow event pulse |
| ctrl_word | output | 32 | Main control word |
| ctrl2_word | output | 32 | Second control word |
| baud_div | output | 9 | Clock divisor |
| module_en | output | 1 | Peripheral enable |
| idle_stop | output | 1 | Halt when the system idles |
| master_en | output | 1 | Drive the serial clock |
| enh_buf_en | output | 1 | Deep FIFO mode |
| hw_ss_en | output | 1 | Slave select driven by hardware |
| framed_en | output | 1 | Framed transfer mode |
| irq_txur_en | output | 1 | Transmit underrun interrupt enable |
| irq_rxov_en | output | 1 | Receive overflow interrupt enable |
| irq_frm_en | output | 1 | Frame error interrupt enable |
| rx_ovf_flag | output | 1 | Sticky receive overflow flag |

## Verification
A register write takes effect at the rising edge where bus_we is sampled. The field pins therefore show the new value half a cycle later, and a read placed in the following cycle returns it one edge after its own read strobe. tx_push and rx_pop are combinational on the strobe cycle, so the bench samples them 1 ns after it drives the strobe at the falling edge. The bench drives every input at a falling edge and reads every output at the next falling edge, so each sample falls exactly one register stage after its cause. Overflow events and the clears that compete with them are placed in chosen cycles, either alone or both in the same cycle, so that the priority between them can be checked.

// File: rtl/spi_csr_pkg.sv
package spi_csr_pkg;

  typedef enum logic [1:0] {
    OP_WR  = 2'd0,
    OP_CLR = 2'd1,
    OP_SET = 2'd2,
    OP_INV = 2'd3
  } csr_op_e;

  typedef enum logic [2:0] {
    TGT_NONE  = 3'd0,
    TGT_CTRL  = 3'd1,
    TGT_STAT  = 3'd2,
    TGT_BUF   = 3'd3,
    TGT_BAUD  = 3'd4,
    TGT_CTRL2 = 3'd5
  } csr_tgt_e;

  // group index = word index / 4; low two word bits select the operation
  localparam int GRP_CTRL  = 0;
  localparam int GRP_STAT  = 1;
  localparam int GRP_BUF   = 2;
  localparam int GRP_BAUD  = 3;
  localparam int GRP_CTRL2 = 4;
  localparam int LAST_WORD = 19;

  localparam int BAUD_W = 9;

  localparam int B_MASTER   = 5;
  localparam int B_IDLESTOP = 13;
  localparam int B_ENABLE   = 15;
  localparam int B_ENHBUF   = 16;
  localparam int B_HWSS     = 28;
  localparam int B_FRAMED   = 31;

  localparam int B_IRQ_TXUR = 10;
  localparam int B_IRQ_RXOV = 11;
  localparam int B_IRQ_FRM  = 12;

  localparam int S_RXEMPTY = 5;
  localparam int S_RXOVF   = 6;
  localparam int S_TXLVL   = 16;
  localparam int S_RXLVL   = 24;

  function automatic logic [31:0] pack_status(input logic [7:0] txl,
                                              input logic [7:0] rxl,
                                              input logic empty,
                                              input logic ovf);
    logic [31:0] s;
    s = '0;
    s[S_TXLVL +: 8] = txl;
    s[S_RXLVL +: 8] = rxl;
    s[S_RXEMPTY]    = empty;
    s[S_RXOVF]      = ovf;
    return s;
  endfunction

endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
  import spi_csr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output csr_tgt_e          tgt,
  output csr_op_e           op
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] grp;
  logic              aligned;

  assign word    = addr[ADDR_W-1:2];
  assign grp     = word >> 2;
  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    tgt = TGT_NONE;
    op  = csr_op_e'(word[1:0]);
    if (aligned && word <= WORD_W'(LAST_WORD)) begin
      if (grp == WORD_W'(GRP_CTRL))       tgt = TGT_CTRL;
      else if (grp == WORD_W'(GRP_STAT))  tgt = TGT_STAT;
      else if (grp == WORD_W'(GRP_CTRL2)) tgt = TGT_CTRL2;
      else if (grp == WORD_W'(GRP_BUF)  && word[1:0] == 2'b00) tgt = TGT_BUF;
      else if (grp == WORD_W'(GRP_BAUD) && word[1:0] == 2'b00) tgt = TGT_BAUD;
    end
    if (tgt == TGT_NONE) op = OP_WR;
  end

endmodule

// File: rtl/csr_alias_reg.sv
module csr_alias_reg
  import spi_csr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  csr_op_e      op,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  function automatic logic [W-1:0] merge(input logic [W-1:0] old,
                                         input logic [W-1:0] d,
                                         input csr_op_e o);
    case (o)
      OP_CLR:  return old & ~d;
      OP_SET:  return old | d;
      OP_INV:  return old ^ d;
      default: return d;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= merge(q, wdata, op);
  end

  AST_CLR_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op == OP_CLR) |=> ((q & $past(wdata)) == '0));  // R3
  AST_SET_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op == OP_SET) |=> ((q & $past(wdata)) == $past(wdata)));  // R4
  AST_INV_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && op == OP_INV) |=> ((q ^ $past(q)) == $past(wdata)));  // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));  // R11

endmodule

// File: rtl/spi_csr_bank.sv
module spi_csr_bank
  import spi_csr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LVL_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              tx_push,
  output logic [31:0]       tx_push_data,
  output logic              rx_pop,
  input  logic [31:0]       rx_pop_data,
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic              rx_empty,
  input  logic              rx_ovf_evt,
  output logic [31:0]       ctrl_word,
  output logic [31:0]       ctrl2_word,
  output logic [BAUD_W-1:0] baud_div,
  output logic              module_en,
  output logic              idle_stop,
  output logic              master_en,
  output logic              enh_buf_en,
  output logic              hw_ss_en,
  output logic              framed_en,
  output logic              irq_txur_en,
  output logic              irq_rxov_en,
  output logic              irq_frm_en,
  output logic              rx_ovf_flag
);

  csr_tgt_e    tgt;
  csr_op_e     op;
  logic        wr_ctrl, wr_ctrl2, wr_baud;
  logic        ovf_clr_req;
  logic        rd_is_alias;
  logic [31:0] status_word;
  logic [31:0] rd_next;

  csr_addr_decode #(.ADDR_W(ADDR_W)) dec_i (
    .addr (bus_addr),
    .tgt  (tgt),
    .op   (op)
  );

  assign wr_ctrl  = bus_we && (tgt == TGT_CTRL);
  assign wr_ctrl2 = bus_we && (tgt == TGT_CTRL2);
  assign wr_baud  = bus_we && (tgt == TGT_BAUD);

  csr_alias_reg #(.W(32)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ctrl), .op(op),
    .wdata(bus_wdata), .q(ctrl_word)
  );

  csr_alias_reg #(.W(32)) ctrl2_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ctrl2), .op(op),
    .wdata(bus_wdata), .q(ctrl2_word)
  );

  csr_alias_reg #(.W(BAUD_W)) baud_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_baud), .op(op),
    .wdata(bus_wdata[BAUD_W-1:0]), .q(baud_div)
  );

  // sticky overflow: hardware event has priority over software clear
  assign ovf_clr_req = bus_we && (tgt == TGT_STAT) && (op == OP_CLR) &&
                       bus_wdata[S_RXOVF];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           rx_ovf_flag <= 1'b0;
    else if (rx_ovf_evt)  rx_ovf_flag <= 1'b1;
    else if (ovf_clr_req) rx_ovf_flag <= 1'b0;
  end

  assign status_word = pack_status(8'(tx_level), 8'(rx_level), rx_empty, rx_ovf_flag);

  assign module_en   = ctrl_word[B_ENABLE];
  assign idle_stop   = ctrl_word[B_IDLESTOP];
  assign master_en   = ctrl_word[B_MASTER];
  assign enh_buf_en  = ctrl_word[B_ENHBUF];
  assign hw_ss_en    = ctrl_word[B_HWSS];
  assign framed_en   = ctrl_word[B_FRAMED];
  assign irq_txur_en = ctrl2_word[B_IRQ_TXUR];
  assign irq_rxov_en = ctrl2_word[B_IRQ_RXOV];
  assign irq_frm_en  = ctrl2_word[B_IRQ_FRM];

  assign tx_push      = bus_we && (tgt == TGT_BUF);
  assign tx_push_data = bus_wdata;
  assign rx_pop       = bus_re && (tgt == TGT_BUF);

  assign rd_is_alias = (op != OP_WR);

  always_comb begin
    rd_next = '0;
    if (!rd_is_alias) begin
      case (tgt)
        TGT_CTRL:  rd_next = ctrl_word;
        TGT_CTRL2: rd_next = ctrl2_word;
        TGT_STAT:  rd_next = status_word;
        TGT_BAUD:  rd_next = 32'(baud_div);
        TGT_BUF:   rd_next = rx_pop_data;
        default:   rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_next;
  end

  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovf_evt |=> rx_ovf_flag);  // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ovf_flag && !ovf_clr_req) |=> rx_ovf_flag);  // R9
  AST_ALIAS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && rd_is_alias) |=> (bus_rdata == '0));  // R11
  AST_BAUD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_baud |=> (baud_div == $past(bus_wdata[BAUD_W-1:0])));  // R6
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata));  // R12
  AST_PUSH_POP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_re) |-> !(tx_push && rx_pop));  // R10

endmodule

// File: tb/spi_csr_bank_tb.sv
module spi_csr_bank_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tx_push, rx_pop;
  logic [31:0] tx_push_data;
  logic [31:0] rx_pop_data = 32'hA5C3_0F1E;
  logic [4:0]  tx_level = '0, rx_level = '0;
  logic        rx_empty = 1'b0, rx_ovf_evt = 1'b0;
  logic [31:0] ctrl_word, ctrl2_word;
  logic [8:0]  baud_div;
  logic        module_en, idle_stop, master_en, enh_buf_en, hw_ss_en, framed_en;
  logic        irq_txur_en, irq_rxov_en, irq_frm_en, rx_ovf_flag;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  spi_csr_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_push(tx_push), .tx_push_data(tx_push_data), .rx_pop(rx_pop),
    .rx_pop_data(rx_pop_data), .tx_level(tx_level), .rx_level(rx_level),
    .rx_empty(rx_empty), .rx_ovf_evt(rx_ovf_evt), .ctrl_word(ctrl_word),
    .ctrl2_word(ctrl2_word), .baud_div(baud_div), .module_en(module_en),
    .idle_stop(idle_stop), .master_en(master_en), .enh_buf_en(enh_buf_en),
    .hw_ss_en(hw_ss_en), .framed_en(framed_en), .irq_txur_en(irq_txur_en),
    .irq_rxov_en(irq_rxov_en), .irq_frm_en(irq_frm_en), .rx_ovf_flag(rx_ovf_flag)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
    v = bus_rdata;
  endtask

  task automatic t_reset();
    chk("R1 ctrl", ctrl_word, 0);
    chk("R1 ctrl2", ctrl2_word, 0);
    chk("R1 baud", 32'(baud_div), 0);
    chk("R1 ovf", 32'(rx_ovf_flag), 0);
    chk("R1 rdata", bus_rdata, 0);
  endtask

  task automatic t_plain();
    logic [31:0] v;
    wr(8'h00, 32'h1234_5678);
    rd(8'h00, v); chk("R2 ctrl readback", v, 32'h1234_5678);
    wr(8'h40, 32'hCAFE_0001);
    rd(8'h40, v); chk("R2 ctrl2 readback", v, 32'hCAFE_0001);
    chk("R12 rdata held", bus_rdata, 32'hCAFE_0001);
  endtask

  task automatic t_aliases();
    logic [31:0] v;
    wr(8'h00, 32'hF0F0_F0F0);
    wr(8'h04, 32'h3000_0030);
    rd(8'h00, v); chk("R3 ctrl clear", v, 32'hC0F0_F0C0);
    wr(8'h08, 32'h0000_000F);
    rd(8'h00, v); chk("R4 ctrl set", v, 32'hC0F0_F0CF);
    wr(8'h0C, 32'hFFFF_0000);
    rd(8'h00, v); chk("R5 ctrl invert", v, 32'h3F0F_F0CF);
    wr(8'h40, 32'h0000_00FF);
    wr(8'h44, 32'h0000_000F);
    chk("R3 ctrl2 clear", ctrl2_word, 32'h0000_00F0);
    wr(8'h48, 32'h8000_0000);
    chk("R4 ctrl2 set", ctrl2_word, 32'h8000_00F0);
    wr(8'h4C, 32'h8000_0110);
    chk("R5 ctrl2 invert", ctrl2_word, 32'h0000_01E0);
  endtask

  task automatic t_baud();
    logic [31:0] v;
    wr(8'h30, 32'hFFFF_FE5A);
    chk("R6 baud port", 32'(baud_div), 32'h05A);
    rd(8'h30, v); chk("R6 baud read", v, 32'h0000_005A);
  endtask

  task automatic t_fields();
    wr(8'h00, 32'h9001_A020);
    chk("R7 ctrl fields",
        {26'd0, module_en, idle_stop, master_en, enh_buf_en, hw_ss_en, framed_en},
        32'h3F);
    wr(8'h04, 32'h0000_8000);
    chk("R7 module_en cleared", 32'(module_en), 0);
    wr(8'h40, 32'h0000_1C00);
    chk("R7 irq fields", {29'd0, irq_txur_en, irq_rxov_en, irq_frm_en}, 32'h7);
    wr(8'h44, 32'h0000_0800);
    chk("R7 rxov cleared", {29'd0, irq_txur_en, irq_rxov_en, irq_frm_en}, 32'h5);
  endtask

  task automatic t_status();
    logic [31:0] v;
    tx_level = 5'h13; rx_level = 5'h0A; rx_empty = 1'b1;
    rd(8'h10, v); chk("R8 status pack", v, 32'h0A13_0020);
    tx_level = 5'h1F; rx_level = 5'h00; rx_empty = 1'b0;
    rd(8'h10, v); chk("R8 status pack 2", v, 32'h001F_0000);
    tx_level = '0;
  endtask

  task automatic t_sticky();
    logic [31:0] v;
    @(negedge clk); rx_ovf_evt = 1'b1;
    @(negedge clk); rx_ovf_evt = 1'b0;
    repeat (3) @(negedge clk);
    rd(8'h10, v); chk("R9 ovf held", v, 32'h0000_0040);
    wr(8'h10, 32'h0000_0000);
    chk("R9 plain write ignored", 32'(rx_ovf_flag), 1);
    wr(8'h1C, 32'h0000_0040);
    chk("R9 invert ignored", 32'(rx_ovf_flag), 1);
    wr(8'h14, 32'hFFFF_FFBF);
    chk("R9 clear without bit6", 32'(rx_ovf_flag), 1);
    wr(8'h14, 32'h0000_0040);
    chk("R9 cleared", 32'(rx_ovf_flag), 0);
    wr(8'h18, 32'h0000_0040);
    chk("R9 set alias ignored", 32'(rx_ovf_flag), 0);
    @(negedge clk); rx_ovf_evt = 1'b1;
    @(negedge clk); rx_ovf_evt = 1'b0;
    @(negedge clk);
    bus_addr = 8'h14; bus_wdata = 32'h40; bus_we = 1'b1; rx_ovf_evt = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; rx_ovf_evt = 1'b0;
    chk("R9 event beats clear", 32'(rx_ovf_flag), 1);
    wr(8'h14, 32'h0000_0040);
  endtask

  task automatic t_buffer();
    logic [31:0] v;
    @(negedge clk);
    bus_addr = 8'h20; bus_wdata = 32'h0BAD_F00D; bus_we = 1'b1;
    #1;
    chk("R10 push strobe", 32'(tx_push), 1);
    chk("R10 push data", tx_push_data, 32'h0BAD_F00D);
    @(negedge clk);
    bus_we = 1'b0;
    #1;
    chk("R10 push one cycle", 32'(tx_push), 0);
    @(negedge clk);
    bus_addr = 8'h20; bus_re = 1'b1;
    #1;
    chk("R10 pop strobe", 32'(rx_pop), 1);
    @(negedge clk);
    bus_re = 1'b0;
    chk("R10 pop data", bus_rdata, 32'hA5C3_0F1E);
    #1;
    chk("R10 pop one cycle", 32'(rx_pop), 0);
    rd(8'h00, v);
    chk("R10 buf write left ctrl", v, 32'h9001_2020);
  endtask

  task automatic t_unused();
    logic [31:0] v;
    rd(8'h08, v); chk("R11 alias read zero", v, 0);
    rd(8'h44, v); chk("R11 ctrl2 alias read zero", v, 0);
    rd(8'h24, v); chk("R11 unused slot zero", v, 0);
    rd(8'h01, v); chk("R11 misaligned zero", v, 0);
    wr(8'h50, 32'hFFFF_FFFF);
    wr(8'h34, 32'hFFFF_FFFF);
    wr(8'h02, 32'hFFFF_FFFF);
    rd(8'h00, v); chk("R11 ctrl untouched", v, 32'h9001_2020);
    rd(8'h30, v); chk("R11 baud untouched", v, 32'h0000_005A);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_plain();
    t_aliases();
    t_baud();
    t_fields();
    t_status();
    t_sticky();
    t_buffer();
    t_unused();
    finish_up();
  end

endmodule